// File: doc/BRIEF.md
# Adjustable Date and Time Keeper

This block keeps a 24-hour time of day and a calendar date, counting from the system clock. A divider turns the clock into a one-second tick; when the fast input is high the divider uses a much shorter ratio, so minutes, hours and days can be watched rolling over in a few cycles.

The user can step the hour and the minute up or down with single-cycle pulses from debounced buttons. A switch value can be written straight into the seconds, and a toggle pulse halts or resumes the tick. A command interface can replace the whole date and time in one cycle. Outputs feed a display driver: BCD hours and minutes, binary seconds for LEDs, and binary day, month and year.

The run control is a two-state machine. In `ST_RUN` each tick advances the time. In `ST_HOLD` ticks are discarded, but adjustments and loads still act. A `pause_tgl_i` pulse moves `ST_RUN` to `ST_HOLD` and `ST_HOLD` to `ST_RUN`. With no pulse the state stays where it is. Reset enters `ST_RUN`.

Top module: `datetime_keeper`

## Requirements
- R1: `hour_bcd_o` and `min_bcd_o` carry the tens digit in bits 7:4 and the units digit in bits 3:0. Hours always lie in 00..23 and minutes in 00..59.
- R2: `sec_o` is a plain binary value that always lies in 0..59.
- R3: After reset the outputs show the parameter values INIT_DAY, INIT_MONTH, INIT_YEAR, INIT_HOUR, INIT_MIN and INIT_SEC. The defaults are 28/2/2024 23:59:50.
- R4: A cycle with `hour_up_i` high and `hour_dn_i` low adds one to the hour, and 23 wraps to 00. The reverse subtracts one, and 00 wraps to 23. Both high leaves the hour unchanged. The date never changes on a manual hour step.
- R5: `min_up_i` and `min_dn_i` step the minute the same way, with wrap between 59 and 00 and no carry into the hour.
- R6: A cycle with `sec_set_i` high loads `sec_sw_i` into the seconds when the value is 59 or less. A larger value is ignored.
- R7: `pause_tgl_i` flips between `ST_RUN` and `ST_HOLD`. In `ST_HOLD` time does not advance, yet adjustments and loads still apply.
- R8: In `ST_RUN` a tick occurs every TICK_DIV cycles, or every FAST_DIV cycles while `fast_i` is high. Each tick adds one second. Seconds carry into minutes, minutes into hours, and 23:59:59 rolls to 00:00:00 and advances the day.
- R9: The day advances through Gregorian month lengths: 30 days in months 4, 6, 9 and 11. February has 29 days in years divisible by 4, except centuries not divisible by 400. All other months have 31 days. Day 31 of month 12 rolls to 1/1 of the next year.
- R10: A cycle with any adjustment input high (hour or minute step, or seconds set) drops a tick that falls in the same cycle.
- R11: `load_i` with in-range fields replaces all six fields at the next clock edge. It overrides adjustments and ticks in that cycle.
- R12: `load_i` with any field out of range is ignored entirely. Out of range means hour > 23, minute or second > 59, month not in 1..12, or day not in 1..(days of that month and year).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_i | input | 1 | Select the short divide ratio for testing |
| pause_tgl_i | input | 1 | Pulse: flip between running and held |
| hour_up_i | input | 1 | Pulse: hour plus one |
| hour_dn_i | input | 1 | Pulse: hour minus one |
| min_up_i | input | 1 | Pulse: minute plus one |
| min_dn_i | input | 1 | Pulse: minute minus one |
| sec_set_i | input | 1 | Load seconds from the switches |
| sec_sw_i | input | 6 | Switch value for seconds |
| load_i | input | 1 | Pulse: load full date and time |
| load_day_i | input | 5 | Day to load, 1..31 |
| load_month_i | input | 4 | Month to load, 1..12 |
| load_year_i | input | YEAR_W | Year to load |
| load_hour_i | input | 5 | Hour to load, 0..23 |
| load_min_i | input | 6 | Minute to load, 0..59 |
| load_sec_i | input | 6 | Second to load, 0..59 |
| hour_bcd_o | output | 8 | Hour as two BCD digits |
| min_bcd_o | output | 8 | Minute as two BCD digits |
| sec_o | output | 6 | Second in binary |
| day_o | output | 5 | Day of month |
| month_o | output | 4 | Month |
| year_o | output | YEAR_W | Year |

## Verification
The bench steps the fields across their wrap points while the clock is held. A design that carried a manual minute step into the hour, or a manual hour step into the day, would show a changed hour or date. It then runs the last second of several months: February in 2000, 1900, 2023 and 2024, plus April and January. A wrong leap rule shows up as 29/2/1900 or 1/3/2000. The bench times the tick gap in both speed modes, and it places a minute step on the exact cycle of a tick; a design that lets both act would show the second moving. Loads are sent with a button pressed alongside and with impossible dates such as 30/2, where a missing range check would corrupt the fields.

// File: rtl/datetime_keeper_pkg.sv
`timescale 1ns/1ps
package datetime_keeper_pkg;

    typedef enum logic {ST_RUN, ST_HOLD} run_state_e;

    function automatic logic is_leap(input logic [15:0] y);
        return ((y % 16'd4) == 16'd0 && (y % 16'd100) != 16'd0) || ((y % 16'd400) == 16'd0);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [15:0] y);
        logic [4:0] d;
        unique case (m)
            4'd2:                      d = is_leap(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] to_bcd(input logic [5:0] v);
        logic [5:0] tens;
        logic [5:0] units;
        tens  = v / 6'd10;
        units = v % 6'd10;
        return {tens[3:0], units[3:0]};
    endfunction

endpackage

// File: rtl/dtk_run_fsm.sv
`timescale 1ns/1ps
module dtk_run_fsm
    import datetime_keeper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic run_en_o
);
    run_state_e state_q;
    run_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = toggle_i ? ST_HOLD : ST_RUN;
            ST_HOLD: state_d = toggle_i ? ST_RUN  : ST_HOLD;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run_en_o = 1'b1;
            ST_HOLD: run_en_o = 1'b0;
            default: run_en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtk_tick_div.sv
`timescale 1ns/1ps
module dtk_tick_div #(
    parameter int TICK_DIV = 200_000_000,
    parameter int FAST_DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    output logic tick_o
);
    localparam int MAX_DIV = (TICK_DIV > FAST_DIV) ? TICK_DIV : FAST_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last   = fast_i ? CNT_W'(FAST_DIV - 1) : CNT_W'(TICK_DIV - 1);
    assign tick_o = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/dtk_calendar.sv
`timescale 1ns/1ps
module dtk_calendar
    import datetime_keeper_pkg::*;
#(
    parameter int YEAR_W     = 14,
    parameter int INIT_DAY   = 28,
    parameter int INIT_MONTH = 2,
    parameter int INIT_YEAR  = 2024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_adv_i,
    input  logic              load_i,
    input  logic [4:0]        load_day_i,
    input  logic [3:0]        load_month_i,
    input  logic [YEAR_W-1:0] load_year_i,
    output logic [4:0]        day_o,
    output logic [3:0]        month_o,
    output logic [YEAR_W-1:0] year_o
);
    logic [4:0]        day_q;
    logic [3:0]        month_q;
    logic [YEAR_W-1:0] year_q;
    logic [4:0]        last_day;

    assign last_day = month_days(month_q, 16'(year_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q   <= 5'(INIT_DAY);
            month_q <= 4'(INIT_MONTH);
            year_q  <= YEAR_W'(INIT_YEAR);
        end else if (load_i) begin
            day_q   <= load_day_i;
            month_q <= load_month_i;
            year_q  <= load_year_i;
        end else if (day_adv_i) begin
            if (day_q >= last_day) begin
                day_q <= 5'd1;
                if (month_q >= 4'd12) begin
                    month_q <= 4'd1;
                    year_q  <= year_q + YEAR_W'(1);
                end else begin
                    month_q <= month_q + 4'd1;
                end
            end else begin
                day_q <= day_q + 5'd1;
            end
        end
    end

    assign day_o   = day_q;
    assign month_o = month_q;
    assign year_o  = year_q;
endmodule

// File: rtl/datetime_keeper.sv
`timescale 1ns/1ps
module datetime_keeper
    import datetime_keeper_pkg::*;
#(
    parameter int TICK_DIV   = 200_000_000,
    parameter int FAST_DIV   = 2000,
    parameter int YEAR_W     = 14,
    parameter int INIT_DAY   = 28,
    parameter int INIT_MONTH = 2,
    parameter int INIT_YEAR  = 2024,
    parameter int INIT_HOUR  = 23,
    parameter int INIT_MIN   = 59,
    parameter int INIT_SEC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_i,
    input  logic              pause_tgl_i,
    input  logic              hour_up_i,
    input  logic              hour_dn_i,
    input  logic              min_up_i,
    input  logic              min_dn_i,
    input  logic              sec_set_i,
    input  logic [5:0]        sec_sw_i,
    input  logic              load_i,
    input  logic [4:0]        load_day_i,
    input  logic [3:0]        load_month_i,
    input  logic [YEAR_W-1:0] load_year_i,
    input  logic [4:0]        load_hour_i,
    input  logic [5:0]        load_min_i,
    input  logic [5:0]        load_sec_i,
    output logic [7:0]        hour_bcd_o,
    output logic [7:0]        min_bcd_o,
    output logic [5:0]        sec_o,
    output logic [4:0]        day_o,
    output logic [3:0]        month_o,
    output logic [YEAR_W-1:0] year_o
);
    logic       run_en;
    logic       tick;
    logic       adjust_any;
    logic       load_ok;
    logic       day_adv;
    logic [4:0] load_last_day;
    logic [4:0] hour_q, hour_d;
    logic [5:0] min_q,  min_d;
    logic [5:0] sec_q,  sec_d;

    dtk_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (pause_tgl_i),
        .run_en_o (run_en)
    );

    dtk_tick_div #(.TICK_DIV(TICK_DIV), .FAST_DIV(FAST_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast_i (fast_i),
        .tick_o (tick)
    );

    // full-load range check; the day bound depends on the loaded month and year
    assign load_last_day = month_days(load_month_i, 16'(load_year_i));
    assign load_ok = load_i
                  && (load_hour_i <= 5'd23) && (load_min_i <= 6'd59) && (load_sec_i <= 6'd59)
                  && (load_month_i >= 4'd1) && (load_month_i <= 4'd12)
                  && (load_day_i >= 5'd1) && (load_day_i <= load_last_day);

    assign adjust_any = hour_up_i | hour_dn_i | min_up_i | min_dn_i | sec_set_i;

    // priority: load, then manual adjustment, then tick
    always_comb begin
        hour_d  = hour_q;
        min_d   = min_q;
        sec_d   = sec_q;
        day_adv = 1'b0;
        if (load_ok) begin
            hour_d = load_hour_i;
            min_d  = load_min_i;
            sec_d  = load_sec_i;
        end else if (adjust_any) begin
            if (hour_up_i && !hour_dn_i)      hour_d = (hour_q >= 5'd23) ? 5'd0 : hour_q + 5'd1;
            else if (hour_dn_i && !hour_up_i) hour_d = (hour_q == 5'd0) ? 5'd23 : hour_q - 5'd1;
            if (min_up_i && !min_dn_i)        min_d  = (min_q >= 6'd59) ? 6'd0 : min_q + 6'd1;
            else if (min_dn_i && !min_up_i)   min_d  = (min_q == 6'd0) ? 6'd59 : min_q - 6'd1;
            if (sec_set_i && (sec_sw_i <= 6'd59)) sec_d = sec_sw_i;
        end else if (run_en && tick) begin
            if (sec_q >= 6'd59) begin
                sec_d = 6'd0;
                if (min_q >= 6'd59) begin
                    min_d = 6'd0;
                    if (hour_q >= 5'd23) begin
                        hour_d  = 5'd0;
                        day_adv = 1'b1;
                    end else begin
                        hour_d = hour_q + 5'd1;
                    end
                end else begin
                    min_d = min_q + 6'd1;
                end
            end else begin
                sec_d = sec_q + 6'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_q <= 5'(INIT_HOUR);
            min_q  <= 6'(INIT_MIN);
            sec_q  <= 6'(INIT_SEC);
        end else begin
            hour_q <= hour_d;
            min_q  <= min_d;
            sec_q  <= sec_d;
        end
    end

    dtk_calendar #(
        .YEAR_W     (YEAR_W),
        .INIT_DAY   (INIT_DAY),
        .INIT_MONTH (INIT_MONTH),
        .INIT_YEAR  (INIT_YEAR)
    ) u_cal (
        .clk          (clk),
        .rst_n        (rst_n),
        .day_adv_i    (day_adv),
        .load_i       (load_ok),
        .load_day_i   (load_day_i),
        .load_month_i (load_month_i),
        .load_year_i  (load_year_i),
        .day_o        (day_o),
        .month_o      (month_o),
        .year_o       (year_o)
    );

    assign hour_bcd_o = to_bcd({1'b0, hour_q});
    assign min_bcd_o  = to_bcd(min_q);
    assign sec_o      = sec_q;
endmodule

// File: rtl/dtk_checker.sv
`timescale 1ns/1ps
module dtk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       hour_up_i,
    input logic       hour_dn_i,
    input logic       min_up_i,
    input logic       min_dn_i,
    input logic       sec_set_i,
    input logic [5:0] sec_sw_i,
    input logic       load_i,
    input logic [7:0] hour_bcd_o,
    input logic [7:0] min_bcd_o,
    input logic [5:0] sec_o
);
    int hr;
    assign hr = int'(hour_bcd_o[7:4]) * 10 + int'(hour_bcd_o[3:0]);

    a_r1_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_bcd_o[7:4] <= 4'd2) && (hour_bcd_o[3:0] <= 4'd9) && (hr <= 23)
        && (min_bcd_o[7:4] <= 4'd5) && (min_bcd_o[3:0] <= 4'd9));

    a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= 6'd59);

    a_r4_hour_up: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_up_i && !hour_dn_i && !load_i) |=> (hr == ($past(hr) + 1) % 24));

    a_r4_hour_down: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_dn_i && !hour_up_i && !load_i) |=> (hr == ($past(hr) + 23) % 24));

    a_r6_sec_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_set_i && (sec_sw_i <= 6'd59) && !load_i) |=> (sec_o == $past(sec_sw_i)));

    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_i && !hour_up_i && !hour_dn_i && !min_up_i && !min_dn_i && !sec_set_i)
        |=> ($stable(sec_o) && $stable(min_bcd_o) && $stable(hour_bcd_o)));

    a_r10_adjust_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (min_up_i && !min_dn_i && !sec_set_i && !load_i) |=> $stable(sec_o));
endmodule

bind datetime_keeper dtk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .hour_up_i  (hour_up_i),
    .hour_dn_i  (hour_dn_i),
    .min_up_i   (min_up_i),
    .min_dn_i   (min_dn_i),
    .sec_set_i  (sec_set_i),
    .sec_sw_i   (sec_sw_i),
    .load_i     (load_i),
    .hour_bcd_o (hour_bcd_o),
    .min_bcd_o  (min_bcd_o),
    .sec_o      (sec_o)
);

// File: tb/datetime_keeper_test.sv
`timescale 1ns/1ps
module datetime_keeper_test;
    localparam int TDIV = 50;
    localparam int FDIV = 4;
    localparam int YW   = 14;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          fast_i = 1'b0, pause_tgl_i = 1'b0;
    logic          hour_up_i = 1'b0, hour_dn_i = 1'b0, min_up_i = 1'b0, min_dn_i = 1'b0;
    logic          sec_set_i = 1'b0;
    logic [5:0]    sec_sw_i = '0;
    logic          load_i = 1'b0;
    logic [4:0]    load_day_i = '0;
    logic [3:0]    load_month_i = '0;
    logic [YW-1:0] load_year_i = '0;
    logic [4:0]    load_hour_i = '0;
    logic [5:0]    load_min_i = '0, load_sec_i = '0;
    logic [7:0]    hour_bcd_o, min_bcd_o;
    logic [5:0]    sec_o;
    logic [4:0]    day_o;
    logic [3:0]    month_o;
    logic [YW-1:0] year_o;

    datetime_keeper #(.TICK_DIV(TDIV), .FAST_DIV(FDIV), .YEAR_W(YW)) uut (
        .clk(clk), .rst_n(rst_n), .fast_i(fast_i), .pause_tgl_i(pause_tgl_i),
        .hour_up_i(hour_up_i), .hour_dn_i(hour_dn_i), .min_up_i(min_up_i), .min_dn_i(min_dn_i),
        .sec_set_i(sec_set_i), .sec_sw_i(sec_sw_i), .load_i(load_i),
        .load_day_i(load_day_i), .load_month_i(load_month_i), .load_year_i(load_year_i),
        .load_hour_i(load_hour_i), .load_min_i(load_min_i), .load_sec_i(load_sec_i),
        .hour_bcd_o(hour_bcd_o), .min_bcd_o(min_bcd_o), .sec_o(sec_o),
        .day_o(day_o), .month_o(month_o), .year_o(year_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bcd(input int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    task automatic chk_time(input string req, input int h, input int m, input int s);
        chk({req, " hour"},   int'(hour_bcd_o), bcd(h));
        chk({req, " minute"}, int'(min_bcd_o),  bcd(m));
        chk({req, " second"}, int'(sec_o),      s);
    endtask

    task automatic chk_date(input string req, input int d, input int mo, input int y);
        chk({req, " day"},   int'(day_o),   d);
        chk({req, " month"}, int'(month_o), mo);
        chk({req, " year"},  int'(year_o),  y);
    endtask

    task automatic press(input bit hu, input bit hd, input bit mu, input bit md);
        @(negedge clk);
        hour_up_i = hu; hour_dn_i = hd; min_up_i = mu; min_dn_i = md;
        @(negedge clk);
        hour_up_i = 1'b0; hour_dn_i = 1'b0; min_up_i = 1'b0; min_dn_i = 1'b0;
    endtask

    task automatic toggle_pause();
        @(negedge clk);
        pause_tgl_i = 1'b1;
        @(negedge clk);
        pause_tgl_i = 1'b0;
    endtask

    task automatic do_load(input int d, input int mo, input int y, input int h, input int m,
                           input int s, input bit with_min_up);
        @(negedge clk);
        load_day_i = 5'(d); load_month_i = 4'(mo); load_year_i = YW'(y);
        load_hour_i = 5'(h); load_min_i = 6'(m); load_sec_i = 6'(s);
        load_i = 1'b1; min_up_i = with_min_up;
        @(negedge clk);
        load_i = 1'b0; min_up_i = 1'b0;
    endtask

    task automatic wait_sec_change(output int cycles);
        logic [5:0] prev;
        prev = sec_o;
        cycles = 0;
        while (sec_o == prev && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        if (cycles >= 1000) chk("R8 tick timeout", cycles, -1);
    endtask

    task automatic t_reset();
        chk_time("R3 reset", 23, 59, 50);
        chk_date("R3 reset", 28, 2, 2024);
    endtask

    task automatic t_hold();
        toggle_pause();
        repeat (200) @(negedge clk);
        chk_time("R7 held time frozen", 23, 59, 50);
    endtask

    task automatic t_hour();
        press(1, 0, 0, 0);
        chk_time("R4 hour up wraps 23->00", 0, 59, 50);
        chk_date("R4 no date change", 28, 2, 2024);
        press(0, 1, 0, 0);
        chk_time("R4 hour down wraps 00->23", 23, 59, 50);
        chk_date("R4 no date change on down", 28, 2, 2024);
        press(1, 1, 0, 0);
        chk_time("R4 up and down cancel", 23, 59, 50);
    endtask

    task automatic t_minute();
        press(0, 0, 1, 0);
        chk_time("R5 minute up wraps, no hour carry", 23, 0, 50);
        press(0, 0, 0, 1);
        chk_time("R5 minute down wraps 00->59", 23, 59, 50);
    endtask

    task automatic t_sec_set();
        @(negedge clk); sec_set_i = 1'b1; sec_sw_i = 6'd30;
        @(negedge clk); sec_set_i = 1'b0;
        chk("R6 seconds set from switches", int'(sec_o), 30);
        @(negedge clk); sec_set_i = 1'b1; sec_sw_i = 6'd60;
        @(negedge clk); sec_set_i = 1'b0;
        chk("R6 out-of-range switch ignored", int'(sec_o), 30);
    endtask

    task automatic t_load();
        do_load(31, 12, 1999, 23, 59, 58, 1'b1);
        chk_time("R11 load overrides minute press", 23, 59, 58);
        chk_date("R11 load", 31, 12, 1999);
        do_load(30, 2, 2001, 12, 0, 0, 1'b0);
        chk_time("R12 bad day ignored", 23, 59, 58);
        chk_date("R12 bad day ignored", 31, 12, 1999);
        do_load(1, 1, 2001, 24, 0, 0, 1'b0);
        chk_time("R12 bad hour ignored", 23, 59, 58);
        do_load(1, 13, 2001, 1, 0, 0, 1'b0);
        chk_date("R12 bad month ignored", 31, 12, 1999);
    endtask

    task automatic t_rollover();
        int c;
        toggle_pause();
        fast_i = 1'b1;
        wait_sec_change(c);
        chk_time("R8 seconds tick", 23, 59, 59);
        wait_sec_change(c);
        chk_time("R8 midnight carry", 0, 0, 0);
        chk_date("R9 new year", 1, 1, 2000);
    endtask

    task automatic t_period();
        int c;
        wait_sec_change(c);
        chk("R8 fast tick period", c, FDIV);
        fast_i = 1'b0;
        wait_sec_change(c);
        wait_sec_change(c);
        chk("R8 normal tick period", c, TDIV);
        fast_i = 1'b1;
        wait_sec_change(c);
        wait_sec_change(c);
        chk("R8 fast tick period again", c, FDIV);
    endtask

    task automatic roll(input string req, input int d, input int mo, input int y,
                        input int ed, input int em, input int ey);
        int c;
        do_load(d, mo, y, 23, 59, 59, 1'b0);
        wait_sec_change(c);
        chk_time({req, " time"}, 0, 0, 0);
        chk_date(req, ed, em, ey);
    endtask

    task automatic t_months();
        roll("R9 2000 is leap",      28, 2, 2000, 29, 2, 2000);
        roll("R9 1900 not leap",     28, 2, 1900,  1, 3, 1900);
        roll("R9 2023 not leap",     28, 2, 2023,  1, 3, 2023);
        roll("R9 leap Feb end",      29, 2, 2024,  1, 3, 2024);
        roll("R9 30-day month",      30, 4, 2023,  1, 5, 2023);
        roll("R9 31-day month",      30, 1, 2023, 31, 1, 2023);
        roll("R9 31-day month end",  31, 1, 2023,  1, 2, 2023);
    endtask

    task automatic t_adjust_vs_tick();
        int c;
        logic [5:0] s0;
        logic [7:0] m0;
        wait_sec_change(c);
        repeat (FDIV - 1) @(negedge clk);
        s0 = sec_o; m0 = min_bcd_o;
        min_up_i = 1'b1;
        @(negedge clk);
        min_up_i = 1'b0;
        chk("R10 tick dropped under press", int'(sec_o), int'(s0));
        chk("R10 press applied", int'(min_bcd_o), bcd(((m0[7:4] * 10 + m0[3:0]) + 1) % 60));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_hour();
        t_minute();
        t_sec_set();
        t_load();
        t_rollover();
        t_period();
        t_months();
        t_adjust_vs_tick();
        finish_run();
    end
endmodule